// File: doc/BRIEF.md
# Radio-Control Bus Serial Byte Receiver

This block receives the serial stream of a radio-control receiver bus and turns it into bytes. Each character on the line has a low start bit and eight data bits, least significant first. An even parity bit follows the data, and the character closes with two high stop bits. The line idles high and runs at 100 kbit/s. The bit period is the clock frequency divided by the baud rate. The line passes through a two-flop synchronizer. A falling edge is confirmed as a start bit by sampling the line again half a bit later. Each later bit is sampled once, in the middle of its bit period.

A controller state machine steps through the states IDLE, START, DATA, PARITY, STOP1 and STOP2:

- IDLE moves to START on a synchronized falling edge.
- START moves to DATA if the half-bit sample is low. If that sample is high, the edge was a glitch and START returns to IDLE.
- DATA moves to PARITY after its eighth sample.
- PARITY moves to STOP1, and STOP1 moves to STOP2, one bit period apart.
- STOP2 moves back to IDLE at its sample point. In the same cycle the block issues a one-cycle byte strobe with the parity-error and framing-error flags.
- Dropping the enable input sends every state to IDLE and discards any partial or stale byte.

Frame assembly and channel decoding belong to a later stage.

Top module: `sbus_rx`

## Requirements
- R1: The line passes through a two-flop synchronizer. For a character whose start bit is first captured at clock edge k0, `rx_valid` is high for exactly the one cycle after edge k0 + 2 + BIT/2 + 11*BIT, where BIT is the bit period in clocks.
- R2: A low pulse that is back high before the half-bit sample point is rejected. No strobe follows it, and the state machine returns to IDLE.
- R3: The eight data bits are taken least significant bit first. Bit i of `rx_byte` is the (i+1)-th bit after the start bit.
- R4: Parity is even. `par_err` is 1 with the strobe when the XOR of the eight data bits and the parity bit is 1, and 0 otherwise.
- R5: `frm_err` is 1 with the strobe when either stop bit samples low. The block still returns to IDLE and receives the next character normally.
- R6: `rx_valid` is a single-cycle pulse. `par_err` and `frm_err` are 0 in every cycle where `rx_valid` is 0.
- R7: While `en` is low, the state machine is held in IDLE, no strobe is produced and `rx_byte` reads 0. A character that is cut off by `en` going low is discarded. Reset gives the same output state.
- R8: The bit period is CLK_HZ / BAUD clocks, with BAUD defaulting to 100000. The half-bit delay is half of that period.
- R9: Characters sent back to back with no idle time between them are each received, with one strobe per character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Receiver enable; low clears and holds the receiver idle |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_byte | output | DATA_BITS | Last received byte, 0 while disabled |
| rx_valid | output | 1 | One-cycle strobe per completed character |
| par_err | output | 1 | Even-parity failure, valid with the strobe |
| frm_err | output | 1 | Stop-bit failure, valid with the strobe |

## Verification
The byte strobe is due at a fixed edge: 2 + BIT/2 + 11*BIT clock edges after the first edge that captures the start bit. With the default parameters this is 186 edges. The bench records that edge, and the expected byte and flags, in a queue when it starts driving each character. On every falling clock edge it compares `rx_valid`, `rx_byte`, `par_err` and `frm_err` with the queue head. A strobe is therefore checked in the exact cycle it is due, and the absence of a strobe is checked in every other cycle. Glitch and enable-drop cases add no queue entry, so any strobe after them is reported at once.

// File: rtl/sbus_rx_pkg.sv
package sbus_rx_pkg;
    typedef enum logic [2:0] {
        SBR_IDLE,
        SBR_START,
        SBR_DATA,
        SBR_PARITY,
        SBR_STOP1,
        SBR_STOP2
    } sbr_state_e;
endpackage

// File: rtl/sbus_rx_sync.sv
module sbus_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_in};
    end

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/sbus_rx_timer.sv
module sbus_rx_timer #(
    parameter int BIT_CLKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic half,
    output logic hit
);
    localparam int HALF_CLKS = BIT_CLKS / 2;
    localparam int CNT_W     = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign hit = half ? (cnt_q == CNT_W'(HALF_CLKS - 1))
                      : (cnt_q == CNT_W'(BIT_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr || hit) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sbus_rx.sv
module sbus_rx
    import sbus_rx_pkg::*;
#(
    parameter int CLK_HZ    = 1_600_000,
    parameter int BAUD      = 100_000,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 rx_in,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 par_err,
    output logic                 frm_err
);
    localparam int BIT_CLKS = CLK_HZ / BAUD;
    localparam int IDX_W    = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    sbr_state_e           state_q, state_d;
    logic                 rx_s, rx_q, fall;
    logic                 tick;
    logic [DATA_BITS-1:0] shreg_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 par_acc_q;
    logic                 stop_bad_q;

    sbus_rx_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_in),
        .d_out (rx_s)
    );

    sbus_rx_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((state_q == SBR_IDLE) || !en),
        .half  (state_q == SBR_START),
        .hit   (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= 1'b1;
        else        rx_q <= rx_s;
    end

    assign fall = rx_q && !rx_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= SBR_IDLE;
        else if (!en) state_q <= SBR_IDLE;
        else          state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SBR_IDLE:   if (fall) state_d = SBR_START;
            SBR_START:  if (tick) state_d = rx_s ? SBR_IDLE : SBR_DATA;
            SBR_DATA:   if (tick && idx_q == IDX_W'(DATA_BITS - 1)) state_d = SBR_PARITY;
            SBR_PARITY: if (tick) state_d = SBR_STOP1;
            SBR_STOP1:  if (tick) state_d = SBR_STOP2;
            SBR_STOP2:  if (tick) state_d = SBR_IDLE;
            default:    state_d = SBR_IDLE;
        endcase
    end

    // shift and check datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q    <= '0;
            idx_q      <= '0;
            par_acc_q  <= 1'b0;
            stop_bad_q <= 1'b0;
        end else if (state_q == SBR_IDLE) begin
            idx_q      <= '0;
            par_acc_q  <= 1'b0;
            stop_bad_q <= 1'b0;
        end else if (tick) begin
            if (state_q == SBR_DATA) begin
                shreg_q   <= {rx_s, shreg_q[DATA_BITS-1:1]};
                idx_q     <= idx_q + 1'b1;
                par_acc_q <= par_acc_q ^ rx_s;
            end
            if (state_q == SBR_PARITY) par_acc_q  <= par_acc_q ^ rx_s;
            if (state_q == SBR_STOP1)  stop_bad_q <= !rx_s;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte  <= '0;
            rx_valid <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
            if (!en) begin
                rx_byte <= '0;
            end else if (state_q == SBR_STOP2 && tick) begin
                rx_valid <= 1'b1;
                rx_byte  <= shreg_q;
                par_err  <= par_acc_q;
                frm_err  <= stop_bad_q || !rx_s;
            end
        end
    end
endmodule

// File: rtl/sbus_rx_chk.sv
module sbus_rx_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic                 rx_valid,
    input logic                 par_err,
    input logic                 frm_err,
    input logic                 in_idle,
    input logic [DATA_BITS-1:0] rx_byte
);
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r6_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> (!par_err && !frm_err));

    a_r7_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> in_idle);

    a_r7_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!rx_valid && rx_byte == '0));

    a_r1_strobe_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (in_idle && !$past(in_idle)));
endmodule

bind sbus_rx sbus_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .rx_valid (rx_valid),
    .par_err  (par_err),
    .frm_err  (frm_err),
    .in_idle  (state_q == sbus_rx_pkg::SBR_IDLE),
    .rx_byte  (rx_byte)
);

// File: tb/sbus_rx_bench.sv
module sbus_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1_600_000;
    localparam int BAUD       = 100_000;
    localparam int BIT        = CLK_HZ / BAUD;
    localparam int HALF       = BIT / 2;

    typedef struct {
        int         cyc;
        logic [7:0] b;
        bit         pe;
        bit         fe;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       rx_in = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid, par_err, frm_err;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   nvalid = 0;
    exp_t expq[$];

    sbus_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_BITS(8)) u_sbus_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .rx_in    (rx_in),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .par_err  (par_err),
        .frm_err  (frm_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic void chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endfunction

    // reference comparison on every clock
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) nvalid++;
            if (expq.size() > 0 && expq[0].cyc == cyc) begin
                exp_t e;
                e = expq.pop_front();
                chk(rx_valid == 1'b1, "R1 R8 strobe timing", int'(rx_valid), 1);
                chk(rx_byte == e.b, "R3 byte value", int'(rx_byte), int'(e.b));
                chk(par_err == e.pe, "R4 parity flag", int'(par_err), int'(e.pe));
                chk(frm_err == e.fe, "R5 framing flag", int'(frm_err), int'(e.fe));
            end else begin
                chk(rx_valid == 1'b0, "R1 no strobe expected", int'(rx_valid), 0);
                chk(!par_err && !frm_err, "R6 flags without strobe",
                    int'({par_err, frm_err}), 0);
            end
        end
    end

    task automatic hold(input logic v, input int n);
        rx_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par,
                        input bit s1, input bit s2);
        exp_t e;
        e.cyc = cyc + 1 + 2 + HALF + 11 * BIT;
        e.b   = d;
        e.pe  = bad_par;
        e.fe  = !(s1 && s2);
        expq.push_back(e);
        hold(1'b0, BIT);
        for (int i = 0; i < 8; i++) hold(d[i], BIT);
        hold((^d) ^ bad_par, BIT);
        hold(s1, BIT);
        hold(s2, BIT);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seen;
        repeat (5) @(negedge clk);
        // R7 reset state
        chk(rx_valid == 1'b0, "R7 reset strobe", int'(rx_valid), 0);
        chk(rx_byte == 8'h00, "R7 reset byte", int'(rx_byte), 0);
        rst_n = 1'b1;
        en    = 1'b1;
        hold(1'b1, 20);

        send(8'hA5, 0, 1, 1);
        hold(1'b1, 30);
        send(8'h01, 0, 1, 1);          // R3 lsb first
        hold(1'b1, 7);
        send(8'h80, 0, 1, 1);
        hold(1'b1, 25);
        send(8'h3C, 1, 1, 1);          // R4 parity fault
        hold(1'b1, 25);
        send(8'hC3, 0, 0, 1);          // R5 first stop low
        send(8'h96, 0, 1, 0);          // R5 second stop low
        hold(1'b1, 3);
        send(8'h69, 0, 1, 1);          // R5 recovery
        // R9 back to back
        send(8'h55, 0, 1, 1);
        send(8'hAA, 1, 1, 1);
        send(8'hFF, 0, 1, 1);
        send(8'h00, 0, 1, 1);
        send(8'h5A, 0, 1, 1);
        hold(1'b1, 2 * BIT);
        chk(expq.size() == 0, "R9 all queued bytes seen", expq.size(), 0);

        // R2 glitch shorter than half a bit
        seen = nvalid;
        hold(1'b0, HALF - 3);
        hold(1'b1, 14 * BIT);
        chk(nvalid == seen, "R2 glitch rejected", nvalid - seen, 0);

        // R7 enable dropped mid-character
        chk(rx_byte == 8'h5A, "R7 byte held before drop", int'(rx_byte), 8'h5A);
        seen = nvalid;
        hold(1'b0, BIT);
        hold(1'b1, BIT);
        hold(1'b0, 2 * BIT);
        en = 1'b0;
        hold(1'b0, 2);
        chk(rx_byte == 8'h00, "R7 byte cleared", int'(rx_byte), 0);
        hold(1'b1, 14 * BIT);
        chk(nvalid == seen, "R7 cut character dropped", nvalid - seen, 0);
        en = 1'b1;
        hold(1'b1, 10);
        send(8'h3E, 0, 1, 1);
        hold(1'b1, 2 * BIT);
        chk(expq.size() == 0, "R7 receive after re-enable", expq.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule